// File: doc/BRIEF.md
# Jump-Gated Interrupt Controller

This block decides when a pipelined processor may leave its program flow to serve one of eight hardware interrupt lines. A rising edge on a line sets a pending bit for that line. The controller takes an interrupt only when three conditions hold in the same cycle: a jump instruction resolves in the memory stage, interrupts are enabled, and the program counter lies in main memory, below the boot ROM base. Keeping interrupts to jump boundaries avoids any interaction with the hazard logic. Keeping them out of ROM means boot code is never interrupted.

When the controller takes an interrupt, it stores the jump's target as the return address and clears the enable flag. One cycle later it issues a redirect to a fixed vector together with a flush request. The number of the serviced line, from 1 to 8, stays readable for the interrupt-ID query instruction. A return-from-interrupt strobe redirects fetch to the stored address and turns interrupts back on. The pipeline performs the flush itself. Interrupts do not nest.

Top module: `jirq_ctrl`

## Requirements
- R1: A pending bit is set only by a 0-to-1 change of its line between consecutive clock edges. A line held high does not set its bit again after the bit has been cleared.
- R2: An interrupt is taken only in a cycle where `jmp_valid` is 1, interrupts are enabled, `cur_pc` is below ROM_BASE (0x7800000), at least one bit is pending, and `reti_valid` is 0.
- R3: A jump whose `cur_pc` is at or above ROM_BASE takes no interrupt and leaves all pending bits unchanged.
- R4: One cycle after an interrupt is taken, `redir_valid` and `flush_req` are both 1 for exactly one cycle, with `redir_addr` equal to VECTOR_ADDR.
- R5: Taking an interrupt clears the enable flag. No further interrupt is taken until a return strobe has been accepted.
- R6: When several lines are pending, the lowest-numbered line is served first. `intid` becomes line number + 1 (a value of 1 to 8) one cycle after the take, and it holds that value until the next take.
- R7: One cycle after `reti_valid`, `redir_valid` and `flush_req` are 1 with `redir_addr` equal to the `jmp_target` of the jump at which the last interrupt was taken. Interrupts are enabled again.
- R8: After reset, `redir_valid`, `flush_req` and `intid` are 0, interrupts are enabled and nothing is pending.
- R9: Taking an interrupt clears only the served line's pending bit. The other pending bits are kept.
- R10: If `reti_valid` and a qualifying jump arrive in the same cycle, the return wins and no interrupt is taken.
- R11: In a cycle with neither an interrupt take nor a return, `redir_valid` and `flush_req` are 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Interrupt request lines, bit i is line i |
| cur_pc | input | 32 | PC of the instruction in the memory stage |
| jmp_valid | input | 1 | A jump resolves in the memory stage this cycle |
| jmp_target | input | 32 | Target address of that jump |
| reti_valid | input | 1 | Return-from-interrupt resolves this cycle |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_addr | output | 32 | Address to redirect to |
| flush_req | output | 1 | Flush request to the pipeline |
| intid | output | 4 | Number of the serviced interrupt (1 to 8), 0 before the first take |

## Verification
The bench raises two lines at once, then jumps from ROM space before jumping from main memory. A controller that does not check the ROM boundary, or that picks the higher line, shows up as a wrong redirect or a wrong `intid`. The bench also keeps lines high across a take and a return. A level-sensitive latch would then take the same interrupt again, and a clear of the wrong bit would lose the second line. Finally, it sends a return and a qualifying jump in the same cycle, and it jumps while interrupts are disabled. A controller with the wrong precedence, or one that never clears the enable flag, would redirect to the vector instead of the saved target.

// File: rtl/jirq_pkg.sv
package jirq_pkg;
  localparam int unsigned IRQ_COUNT = 8;
  localparam int unsigned IRQ_ID_W  = $clog2(IRQ_COUNT + 1);

  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_TAKE = 2'd1,
    EVT_RET  = 2'd2
  } evt_e;
endpackage

// File: rtl/jirq_capture.sv
module jirq_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pending
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic rise;
      assign rise = lines[g] & ~prev_q[g];
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q[g] <= 1'b0;
          pend_q[g] <= 1'b0;
        end else begin
          prev_q[g] <= lines[g];
          pend_q[g] <= (pend_q[g] & ~clr[g]) | rise;
        end
      end
    end
  endgenerate

  assign pending = pend_q;
endmodule

// File: rtl/jirq_select.sv
module jirq_select #(
  parameter int unsigned N    = 8,
  parameter int unsigned ID_W = 4
) (
  input  logic [N-1:0]    pending,
  output logic            any,
  output logic [N-1:0]    grant,
  output logic [ID_W-1:0] id
);
  always_comb begin
    grant = '0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        id       = ID_W'(i + 1);
      end
    end
  end

  assign any = |pending;
endmodule

// File: rtl/jirq_context.sv
module jirq_context
  import jirq_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned ID_W        = 4,
  parameter logic [AW-1:0] VECTOR_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  evt_e            evt,
  input  logic [AW-1:0]   ret_addr,
  input  logic [ID_W-1:0] new_id,
  output logic            enabled,
  output logic            redir_valid,
  output logic [AW-1:0]   redir_addr,
  output logic            flush_req,
  output logic [ID_W-1:0] svc_id
);
  logic [AW-1:0] saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled     <= 1'b1;
      saved_q     <= '0;
      svc_id      <= '0;
      redir_valid <= 1'b0;
      flush_req   <= 1'b0;
      redir_addr  <= '0;
    end else begin
      unique case (evt)
        EVT_TAKE: begin
          enabled     <= 1'b0;
          saved_q     <= ret_addr;
          svc_id      <= new_id;
          redir_valid <= 1'b1;
          flush_req   <= 1'b1;
          redir_addr  <= VECTOR_ADDR;
        end
        EVT_RET: begin
          enabled     <= 1'b1;
          redir_valid <= 1'b1;
          flush_req   <= 1'b1;
          redir_addr  <= saved_q;
        end
        default: begin
          redir_valid <= 1'b0;
          flush_req   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/jirq_ctrl.sv
module jirq_ctrl
  import jirq_pkg::*;
#(
  parameter int unsigned   AW          = 32,
  parameter logic [AW-1:0] ROM_BASE    = 32'h0780_0000,
  parameter logic [AW-1:0] VECTOR_ADDR = 32'h0000_0100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IRQ_COUNT-1:0] irq_lines,
  input  logic [AW-1:0]        cur_pc,
  input  logic                 jmp_valid,
  input  logic [AW-1:0]        jmp_target,
  input  logic                 reti_valid,
  output logic                 redir_valid,
  output logic [AW-1:0]        redir_addr,
  output logic                 flush_req,
  output logic [IRQ_ID_W-1:0]  intid
);
  logic [IRQ_COUNT-1:0] pending;
  logic [IRQ_COUNT-1:0] grant;
  logic [IRQ_COUNT-1:0] clr;
  logic                 any_pend;
  logic [IRQ_ID_W-1:0]  pick_id;
  logic                 enabled;
  logic                 in_main;
  logic                 take;
  evt_e                 evt;

  jirq_capture #(.N(IRQ_COUNT)) u_capture (
    .clk(clk), .rst(rst), .lines(irq_lines), .clr(clr), .pending(pending)
  );

  jirq_select #(.N(IRQ_COUNT), .ID_W(IRQ_ID_W)) u_select (
    .pending(pending), .any(any_pend), .grant(grant), .id(pick_id)
  );

  assign in_main = (cur_pc < ROM_BASE);
  assign take    = jmp_valid & enabled & in_main & any_pend & ~reti_valid;
  assign clr     = take ? grant : '0;

  always_comb begin
    if (reti_valid)  evt = EVT_RET;
    else if (take)   evt = EVT_TAKE;
    else             evt = EVT_NONE;
  end

  jirq_context #(.AW(AW), .ID_W(IRQ_ID_W), .VECTOR_ADDR(VECTOR_ADDR)) u_context (
    .clk(clk), .rst(rst), .evt(evt), .ret_addr(jmp_target), .new_id(pick_id),
    .enabled(enabled), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .flush_req(flush_req), .svc_id(intid)
  );
endmodule

// File: rtl/jirq_ctrl_checker.sv
module jirq_ctrl_checker #(
  parameter int unsigned   AW       = 32,
  parameter logic [AW-1:0] ROM_BASE = 32'h0780_0000
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cur_pc,
  input logic          jmp_valid,
  input logic          reti_valid,
  input logic          redir_valid,
  input logic          flush_req,
  input logic [3:0]    intid
);
  // R4 / R7: every redirect comes with a flush
  a_r4_flush_with_redirect: assert property (@(posedge clk) disable iff (rst)
    redir_valid == flush_req);

  // R3: a jump from ROM space never leads to a redirect unless a return came with it
  a_r3_rom_no_take: assert property (@(posedge clk) disable iff (rst)
    (jmp_valid && cur_pc >= ROM_BASE && !reti_valid) |=> !redir_valid);

  // R11: no jump and no return, so no redirect
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!jmp_valid && !reti_valid) |=> !redir_valid);

  // R7: a return always redirects
  a_r7_return_redirects: assert property (@(posedge clk) disable iff (rst)
    reti_valid |=> redir_valid);

  // R6: id within 0..8 and stable without a jump
  a_r6_id_range: assert property (@(posedge clk) disable iff (rst)
    intid <= 4'd8);
  a_r6_id_stable: assert property (@(posedge clk) disable iff (rst)
    !jmp_valid |=> $stable(intid));
endmodule

bind jirq_ctrl jirq_ctrl_checker #(.AW(AW), .ROM_BASE(ROM_BASE)) u_checker (
  .clk(clk), .rst(rst), .cur_pc(cur_pc), .jmp_valid(jmp_valid),
  .reti_valid(reti_valid), .redir_valid(redir_valid), .flush_req(flush_req),
  .intid(intid)
);

// File: tb/jirq_ctrl_bench.sv
`timescale 1ns/1ps
module jirq_ctrl_bench;
  localparam logic [31:0] ROMB = 32'h0780_0000;
  localparam logic [31:0] VEC  = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_lines = '0;
  logic [31:0] cur_pc = '0;
  logic        jmp_valid = 1'b0;
  logic [31:0] jmp_target = '0;
  logic        reti_valid = 1'b0;
  logic        redir_valid;
  logic [31:0] redir_addr;
  logic        flush_req;
  logic [3:0]  intid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  jirq_ctrl #(.ROM_BASE(ROMB), .VECTOR_ADDR(VEC)) u_jirq_ctrl (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .cur_pc(cur_pc),
    .jmp_valid(jmp_valid), .jmp_target(jmp_target), .reti_valid(reti_valid),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .flush_req(flush_req),
    .intid(intid)
  );

  // reference model state
  logic [7:0]  m_prev, m_pend;
  logic        m_ie, e_rv;
  logic [31:0] m_saved, e_addr;
  logic [3:0]  m_id;
  string       e_tag;

  function automatic int lowest(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_pend = '0; m_ie = 1'b1; m_saved = '0; m_id = '0;
    e_rv = 1'b0; e_addr = '0;
  endtask

  task automatic step(input logic [7:0] ln, input logic [31:0] pc, input logic j,
                      input logic [31:0] tg, input logic r);
    logic [7:0] rise;
    logic [7:0] clr;
    int lo;
    @(negedge clk);
    irq_lines = ln; cur_pc = pc; jmp_valid = j; jmp_target = tg; reti_valid = r;
    rise = ln & ~m_prev;
    clr  = '0;
    lo   = lowest(m_pend);
    if (r) begin
      e_rv = 1'b1; e_addr = m_saved; m_ie = 1'b1; e_tag = "R7";
    end else if (j && m_ie && pc < ROMB && lo >= 0) begin
      e_rv = 1'b1; e_addr = VEC; m_ie = 1'b0; m_saved = tg;
      m_id = 4'(lo + 1); clr[lo] = 1'b1; e_tag = "R4";
    end else begin
      e_rv = 1'b0;
      e_tag = (j && pc >= ROMB) ? "R3" : (j ? "R2" : "R11");
    end
    m_pend = (m_pend & ~clr) | rise;
    m_prev = ln;
    @(posedge clk); #1;
    chk(e_tag, {31'd0, redir_valid}, {31'd0, e_rv});
    chk(e_tag, {31'd0, flush_req}, {31'd0, e_rv});
    if (e_rv) chk(e_tag, redir_addr, e_addr);
    chk("R6", {28'd0, intid}, {28'd0, m_id});
  endtask

  initial begin
    #(4 * 40000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] ln;
    seed = $urandom(32'd4242);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0.5;
    // R8: reset state
    chk("R8", {31'd0, redir_valid}, 32'd0);
    chk("R8", {31'd0, flush_req}, 32'd0);
    chk("R8", {28'd0, intid}, 32'd0);

    // directed: lines 2 and 5 rise together
    step(8'h24, 32'h1000, 1'b0, 32'h0, 1'b0);
    // R3: jump from ROM space takes nothing
    step(8'h24, ROMB + 32'd4, 1'b1, 32'h2000, 1'b0);
    chk("R3", {31'd0, redir_valid}, 32'd0);
    // R6: lowest line (2) served, id 3
    step(8'h24, 32'h1000, 1'b1, 32'h2000, 1'b0);
    chk("R6", {28'd0, intid}, 32'd3);
    chk("R4", redir_addr, VEC);
    // R5: enable cleared, next jump takes nothing
    step(8'h24, 32'h1004, 1'b1, 32'h2400, 1'b0);
    chk("R5", {31'd0, redir_valid}, 32'd0);
    // R7: return to saved target
    step(8'h24, 32'h0, 1'b0, 32'h0, 1'b1);
    chk("R7", redir_addr, 32'h2000);
    // R9: line 5 still pending, served now
    step(8'h24, 32'h1000, 1'b1, 32'h3000, 1'b0);
    chk("R9", {28'd0, intid}, 32'd6);
    // R10: return and jump together, return wins
    step(8'h24, 32'h1000, 1'b1, 32'h5000, 1'b1);
    chk("R10", redir_addr, 32'h3000);
    // R1: held lines do not retrigger
    step(8'h24, 32'h1000, 1'b1, 32'h6000, 1'b0);
    chk("R1", {31'd0, redir_valid}, 32'd0);
    step(8'h00, 32'h1000, 1'b0, 32'h0, 1'b0);

    // constrained random
    ln = '0;
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] pc;
      logic j, r;
      if (($urandom % 4) == 0) ln = ln ^ 8'($urandom);
      pc = (($urandom % 4) == 0) ? ROMB + ($urandom % 32'h400) : ($urandom % ROMB);
      j  = (($urandom % 10) < 3);
      r  = (($urandom % 10) == 0);
      step(ln, pc, j, $urandom, r);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule